// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Maskable-Source Elevation

This block decides which pending interrupt the CPU should take next. It produces a pending flag and a 16-bit vector address in the 0xFFxx page. Two kinds of request compete. The first kind is non-maskable: a group of reset-type sources with a fixed order, and an external active-low pin that is blocked only by the X mask. The second kind is maskable: a level-sensitive external request line whose polarity is programmable, and a set of peripheral sources. Each peripheral source counts only when both its flag and its local enable are set. The global I mask blocks every maskable source.

The block keeps the X and I mask bits as state. Software writes to them through a write strobe. I can be written to either value, but X can only be cleared. When the CPU acknowledges the pending interrupt, the masks are raised: entering a non-maskable interrupt sets both X and I, and entering a maskable one sets only I.

A priority-select register holds a vector low byte in bits 7:1, and bit 0 always reads 0. The maskable source whose vector matches that byte moves above all other maskable sources. The rest of the maskable sources keep their default order, in which a higher vector address wins. Non-maskable ordering never changes.

Vector low bytes with the default parameters:

| Source | Vector low byte |
|---|---|
| Reset-type source i | 0xFE − 2i (0xFE down to 0xF6) |
| External non-maskable pin | 0xF4 |
| External maskable line | 0xF2 |
| Peripheral p | 0xF0 − 2p (0xF0 down to 0xBC) |

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the masks are X=1 and I=1, irq_pend is 0, vec_addr is 0x0000 and psel_rd reads 0xF2.
- R2: Reset-type source i (index 0 is the highest) gives vector 0xFF00|(0xFE−2i). Any active reset-type source wins over every other source, whatever X and I hold.
- R3: The external non-maskable pin is active low and gives vector 0xFFF4. It wins over all maskable sources. While X=1 it is ignored and raises no pending flag.
- R4: While I=1, no maskable source raises irq_pend.
- R5: Peripheral p is a candidate only when periph_flag[p] and periph_en[p] are both 1. Its vector is 0xFF00|(0xF0−2p).
- R6: The external maskable line is active when irq_pin equals irq_pol. So irq_pol=1 selects active-high and irq_pol=0 selects active-low. Its vector is 0xFFF2.
- R7: Among maskable candidates that are not promoted, the one with the higher vector address wins, so the maskable line beats peripheral 0, and peripheral 0 beats peripheral 1.
- R8: psel_wr stores psel_wdata[7:1], and psel_rd bit 0 always reads 0. The maskable source whose vector low byte equals the stored byte wins over all other maskable candidates. For example, writing 0xDE (or 0xDF) promotes peripheral 9.
- R9: A stored byte that matches no maskable vector leaves the default order in force.
- R10: On ccr_wr, I takes ccr_wr_i and X becomes X AND ccr_wr_x. A write can therefore clear X but never set it.
- R11: int_ack while irq_pend is 1 sets both X and I if the pending source is non-maskable, and sets only I otherwise. An acknowledge takes precedence over a ccr_wr in the same cycle.
- R12: irq_pend and vec_addr are registered, so they follow the inputs one clock later. vec_addr is always 0xFF00 plus the winner's low byte while irq_pend is 1.
- R13: The priority-select register does not alter the order of the non-maskable sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | N_NMI | Reset-type non-maskable requests; index 0 is the highest |
| xirq_n | input | 1 | External non-maskable request, active low |
| irq_pin | input | 1 | External maskable request line |
| irq_pol | input | 1 | Active level of irq_pin: 1 high, 0 low |
| periph_flag | input | N_PERIPH | Peripheral request flags |
| periph_en | input | N_PERIPH | Peripheral local enables |
| ccr_wr | input | 1 | Software mask write strobe |
| ccr_wr_x | input | 1 | X value written (it can only clear X) |
| ccr_wr_i | input | 1 | I value written |
| int_ack | input | 1 | CPU takes the pending interrupt |
| psel_wr | input | 1 | Priority-select write strobe |
| psel_wdata | input | 8 | Priority-select write data |
| irq_pend | output | 1 | An interrupt is pending |
| vec_addr | output | 16 | Vector address of the winner |
| psel_rd | output | 8 | Priority-select readback |
| mask_x | output | 1 | Current X mask |
| mask_i | output | 1 | Current I mask |

## Verification
Some rules are checked on every cycle:
- X rises only after an acknowledged non-maskable entry.
- A set I mask never lets a maskable vector through, and a set X mask never lets the external pin's vector through.
- Reset-type requests always produce a non-maskable vector in the next cycle.
- The vector page is 0xFF, and bit 0 of the priority-select readback is 0.

Only the bench scenarios can show the following:
- The exact winner under competing requests, meaning the default order, promotion by a written byte (including the ignored bit 0) and the fallback for an unmatched byte.
- The two IRQ polarities, and the need for both flag and enable.
- The one-cycle output latency.

// File: rtl/ipc_pkg.sv
// Package: vector low-byte arithmetic shared by the controller and its checker.
// Assumes vectors are two bytes apart, descending from 0xFE: reset-type
// sources first, then the external non-maskable pin, then the maskable sources.
package ipc_pkg;
    // Low byte of reset-type source i
    function automatic logic [7:0] nmi_lo(input int i);
        return 8'(254 - 2 * i);
    endfunction

    // Low byte of the external non-maskable pin
    function automatic logic [7:0] xirq_lo(input int n_nmi);
        return 8'(254 - 2 * n_nmi);
    endfunction

    // Low byte of maskable source m (0 = external line, m = p+1 for peripheral p)
    function automatic logic [7:0] mask_lo(input int n_nmi, input int m);
        return 8'(254 - 2 * (n_nmi + 1) - 2 * m);
    endfunction
endpackage

// File: rtl/ipc_mask_state.sv
// Holds the X and I condition-code masks.
// Assumes ack_nm and ack_mk are never both 1. An acknowledge has priority over
// a software write. A software write can only clear X.
module ipc_mask_state (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_nm,
    input  logic ack_mk,
    input  logic ccr_wr,
    input  logic ccr_wr_x,
    input  logic ccr_wr_i,
    output logic mask_x,
    output logic mask_i
);
    // Update both masks from acknowledges and software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_x <= 1'b1;
            mask_i <= 1'b1;
        end else if (ack_nm) begin
            mask_x <= 1'b1;
            mask_i <= 1'b1;
        end else if (ack_mk) begin
            mask_i <= 1'b1;
        end else if (ccr_wr) begin
            mask_x <= mask_x & ccr_wr_x;
            mask_i <= ccr_wr_i;
        end
    end
endmodule

// File: rtl/ipc_psel_reg.sv
// Priority-select register: stores bits 7:1 of the written byte, and bit 0
// reads as 0. Assumes the reset value names a valid vector low byte.
module ipc_psel_reg #(
    parameter logic [7:0] RESET_VAL = 8'hF2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psel_wr,
    input  logic [7:0] psel_wdata,
    output logic [7:0] psel_rd
);
    logic [6:0] sel_q;

    // Capture the upper seven bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= RESET_VAL[7:1];
        else if (psel_wr) sel_q <= psel_wdata[7:1];
    end

    assign psel_rd = {sel_q, 1'b0};
endmodule

// File: rtl/ipc_mask_arb.sv
// Maskable arbiter: a promoted candidate (vector equal to the select byte)
// wins. Otherwise the lowest index wins, which is the highest vector address.
// Assumes all vector bytes are distinct, so at most one source is promoted.
module ipc_mask_arb #(
    parameter int N_NMI  = 5,
    parameter int N_MASK = 28,
    localparam int IW    = $clog2(N_MASK)
) (
    input  logic [N_MASK-1:0] act,
    input  logic              gmask,
    input  logic [7:0]        psel,
    output logic              valid,
    output logic [7:0]        lo
);
    logic [N_MASK-1:0] promo;
    logic [N_MASK-1:0] cand;
    logic [IW-1:0]     win_def;
    logic [IW-1:0]     win_pro;
    logic              any_pro;

    // Compare each source's fixed vector with the select byte
    for (genvar m = 0; m < N_MASK; m++) begin : g_match
        assign promo[m] = (psel[7:1] == ipc_pkg::mask_lo(N_NMI, m)[7:1]);
    end

    assign cand    = gmask ? '0 : act;
    assign any_pro = |(cand & promo);
    assign valid   = |cand;

    // Priority-encode the default order and the promoted candidate
    always_comb begin
        win_def = '0;
        win_pro = '0;
        for (int m = N_MASK - 1; m >= 0; m--) begin
            if (cand[m])            win_def = IW'(m);
            if (cand[m] && promo[m]) win_pro = IW'(m);
        end
    end

    assign lo = ipc_pkg::mask_lo(N_NMI, int'(any_pro ? win_pro : win_def));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the interrupt controller: picks between the reset-type group, the
// external non-maskable pin and the maskable arbiter, and registers the
// pending flag and the vector. Assumes the inputs are synchronous to clk.
module irq_prio_ctrl #(
    parameter int N_NMI    = 5,
    parameter int N_PERIPH = 27,
    localparam int N_MASK  = N_PERIPH + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_NMI-1:0]    nmi_req,
    input  logic                xirq_n,
    input  logic                irq_pin,
    input  logic                irq_pol,
    input  logic [N_PERIPH-1:0] periph_flag,
    input  logic [N_PERIPH-1:0] periph_en,
    input  logic                ccr_wr,
    input  logic                ccr_wr_x,
    input  logic                ccr_wr_i,
    input  logic                int_ack,
    input  logic                psel_wr,
    input  logic [7:0]          psel_wdata,
    output logic                irq_pend,
    output logic [15:0]         vec_addr,
    output logic [7:0]          psel_rd,
    output logic                mask_x,
    output logic                mask_i
);
    logic [N_MASK-1:0] act;
    logic              m_valid;
    logic [7:0]        m_lo;
    logic              win_valid;
    logic              win_nm;
    logic [7:0]        win_lo;
    logic              nm_q;
    logic [7:0]        lo_q;
    logic              ack_nm;
    logic              ack_mk;

    assign act    = {periph_flag & periph_en, irq_pin == irq_pol};
    assign ack_nm = int_ack & irq_pend & nm_q;
    assign ack_mk = int_ack & irq_pend & ~nm_q;

    ipc_mask_state u_mask (
        .clk(clk), .rst_n(rst_n), .ack_nm(ack_nm), .ack_mk(ack_mk),
        .ccr_wr(ccr_wr), .ccr_wr_x(ccr_wr_x), .ccr_wr_i(ccr_wr_i),
        .mask_x(mask_x), .mask_i(mask_i)
    );

    ipc_psel_reg #(.RESET_VAL(ipc_pkg::mask_lo(N_NMI, 0))) u_psel (
        .clk(clk), .rst_n(rst_n), .psel_wr(psel_wr),
        .psel_wdata(psel_wdata), .psel_rd(psel_rd)
    );

    ipc_mask_arb #(.N_NMI(N_NMI), .N_MASK(N_MASK)) u_arb (
        .act(act), .gmask(mask_i), .psel(psel_rd),
        .valid(m_valid), .lo(m_lo)
    );

    // Combine non-maskable and maskable winners in fixed priority
    always_comb begin
        win_valid = m_valid;
        win_nm    = 1'b0;
        win_lo    = m_lo;
        if (!xirq_n && !mask_x) begin
            win_valid = 1'b1;
            win_nm    = 1'b1;
            win_lo    = ipc_pkg::xirq_lo(N_NMI);
        end
        for (int i = N_NMI - 1; i >= 0; i--) begin
            if (nmi_req[i]) begin
                win_valid = 1'b1;
                win_nm    = 1'b1;
                win_lo    = ipc_pkg::nmi_lo(i);
            end
        end
    end

    // Register the pending flag, the vector and the winner's kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
            nm_q     <= 1'b0;
            lo_q     <= 8'h00;
        end else begin
            irq_pend <= win_valid;
            nm_q     <= win_nm;
            lo_q     <= win_valid ? win_lo : 8'h00;
        end
    end

    assign vec_addr = irq_pend ? {8'hFF, lo_q} : 16'h0000;
endmodule

// File: rtl/ipc_checker.sv
// Checker for irq_prio_ctrl: per-cycle rules on masks, vector page and winners.
// Assumes the same N_NMI as the controller it is bound to.
module ipc_checker #(
    parameter int N_NMI = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_NMI-1:0] nmi_req,
    input logic             int_ack,
    input logic             irq_pend,
    input logic [15:0]      vec_addr,
    input logic [7:0]       psel_rd,
    input logic             mask_x,
    input logic             mask_i
);
    localparam logic [7:0] XLO = ipc_pkg::xirq_lo(N_NMI);

    assert_vec_page_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> vec_addr[15:8] == 8'hFF);

    assert_psel_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        psel_rd[0] == 1'b0);

    assert_x_set_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_x) |-> $past(int_ack && irq_pend && vec_addr[7:0] >= XLO));

    assert_imask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_i) && irq_pend) |-> vec_addr[7:0] >= XLO);

    assert_xmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_x) && irq_pend) |-> vec_addr[7:0] != XLO);

    assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|nmi_req)) |-> (irq_pend && vec_addr[7:0] > XLO));
endmodule

bind irq_prio_ctrl ipc_checker #(.N_NMI(N_NMI)) u_chk (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .int_ack(int_ack),
    .irq_pend(irq_pend), .vec_addr(vec_addr), .psel_rd(psel_rd),
    .mask_x(mask_x), .mask_i(mask_i)
);

// File: tb/sim_irq_prio_ctrl.sv
// Scoreboard bench: driver tasks push expected outputs, a monitor compares them.
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  nmi_req = '0;
    logic        xirq_n = 1'b1, irq_pin = 1'b0, irq_pol = 1'b1;
    logic [26:0] periph_flag = '0, periph_en = '0;
    logic        ccr_wr = 1'b0, ccr_wr_x = 1'b0, ccr_wr_i = 1'b0;
    logic        int_ack = 1'b0, psel_wr = 1'b0;
    logic [7:0]  psel_wdata = '0;
    logic        irq_pend, mask_x, mask_i;
    logic [15:0] vec_addr;
    logic [7:0]  psel_rd;

    int checks = 0, fails = 0;
    logic [16:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl u0 (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop an expected item and compare it with the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [16:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {15'd0, irq_pend}, {15'd0, e[16]});
            chk(t, vec_addr, e[15:0]);
        end
    end

    // Let inputs settle through the registers, then queue the expected result
    task automatic expect_out(input string tag, input logic p, input logic [7:0] lo);
        repeat (3) @(posedge clk);
        exp_q.push_back({p, p ? {8'hFF, lo} : 16'h0000});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic ccr(input logic x, input logic i);
        @(negedge clk); ccr_wr = 1; ccr_wr_x = x; ccr_wr_i = i;
        @(negedge clk); ccr_wr = 0;
    endtask

    task automatic psel(input logic [7:0] d);
        @(negedge clk); psel_wr = 1; psel_wdata = d;
        @(negedge clk); psel_wr = 0;
    endtask

    task automatic ack();
        @(negedge clk); int_ack = 1;
        @(negedge clk); int_ack = 0;
    endtask

    task automatic masks(input string tag, input logic x, input logic i);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(tag, {14'd0, mask_x, mask_i}, {14'd0, x, i});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 pend", {15'd0, irq_pend}, 16'd0);
        chk("R1 vec", vec_addr, 16'h0000);
        chk("R1 masks", {14'd0, mask_x, mask_i}, 16'd3);
        chk("R1 psel", {8'd0, psel_rd}, 16'h00F2);

        periph_flag[3] = 1; periph_en[3] = 1;
        expect_out("R4 I blocks", 0, 8'h00);
        ccr(0, 0);
        masks("R10 clear X", 0, 0);
        expect_out("R5 periph3", 1, 8'hEA);
        periph_flag[5] = 1; periph_en[1] = 1;
        expect_out("R5 flag or enable alone", 1, 8'hEA);
        periph_flag[1] = 1;
        expect_out("R7 periph1 over periph3", 1, 8'hEE);
        irq_pin = 1; irq_pol = 1;
        expect_out("R6 active-high", 1, 8'hF2);
        irq_pol = 0;
        expect_out("R6 high ignored when active-low", 1, 8'hEE);
        irq_pin = 0;
        expect_out("R6 active-low", 1, 8'hF2);
        irq_pol = 1;

        psel(8'hDF);
        chk("R8 readback bit0", {8'd0, psel_rd}, 16'h00DE);
        periph_flag[9] = 1; periph_en[9] = 1;
        expect_out("R8 promoted periph9", 1, 8'hDE);
        irq_pin = 1;
        expect_out("R8 promoted over IRQ", 1, 8'hDE);
        irq_pin = 0;
        psel(8'h00);
        expect_out("R9 unmatched byte", 1, 8'hEE);

        xirq_n = 0;
        expect_out("R3 xirq", 1, 8'hF4);
        psel(8'hFA);
        nmi_req[2] = 1;
        expect_out("R2 source2", 1, 8'hFA);
        nmi_req[1] = 1;
        expect_out("R13 order kept", 1, 8'hFC);
        nmi_req[0] = 1;
        expect_out("R2 source0", 1, 8'hFE);
        ack();
        masks("R11 nmi entry", 1, 1);
        nmi_req = '0;
        expect_out("R3 xirq masked", 0, 8'h00);

        ccr(0, 0);
        ccr(1, 0);
        masks("R10 X not settable", 0, 0);
        expect_out("R3 xirq unmasked", 1, 8'hF4);
        xirq_n = 1;
        expect_out("R7 default", 1, 8'hEE);
        ack();
        masks("R11 maskable entry", 0, 1);
        expect_out("R4 I set", 0, 8'h00);

        periph_flag = '0; periph_en = '0;
        ccr(0, 0);
        expect_out("R12 idle", 0, 8'h00);
        @(negedge clk); periph_flag[0] = 1; periph_en[0] = 1;
        @(negedge clk);
        chk("R12 latency vec", vec_addr, 16'hFFF0);
        done = 1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule